// File: doc/BRIEF.md
# Paged Packet Buffer Allocator

This block keeps track of a packet buffer that is cut into fixed 256-byte pages. The host drives an 8-bit command byte. Bits [7:5] select the operation. For an allocation, the low five bits hold the page count minus one. The block answers with a result byte that names the packet, and it keeps a per-packet record of which pages that packet owns. The MAC side is reduced to two strobes. One pushes a finished receive packet into the receive queue. The other pops the head of the transmit queue once that frame has gone out.

The host sees four things: the allocation result, a busy flag that covers a page release, a queue-head word for both queues, and a memory word that gives the free and total page counts. Freeing is a timed operation of fixed length. While it runs, every command except a reset is dropped. The page data RAM is not part of this block.

Top module: `pba_alloc`

## Requirements
- R1: After reset the block shows the following. The result byte is 0x80. The queue-head word is 0x8080, meaning both queues are empty. The memory word shows all pages free. Busy is low.
- R2: Opcode 1 (byte 0x20 | (pages-1)) takes the lowest-addressed run of contiguous free pages of that length. It gives the packet the lowest unused packet number. The result byte appears in the cycle after the write, with bit 7 clear and the number in bits [6:0]. alloc_done is high for exactly that one cycle.
- R3: If no contiguous run of that length is free, or no packet number is free, the result byte becomes 0x80. In that case alloc_done stays low and no pages change.
- R4: The memory word holds the free page count in bits [15:8] and the total page count (NUM_PAGES) in bits [7:0].
- R5: Opcode 5 (0xA0) frees the packet held in the packet-number register. Busy is high for exactly 4 cycles, starting in the cycle after the write. The packet's pages and its number come back when busy falls.
- R6: Opcode 5 aimed at a packet number that is not allocated raises no busy and changes nothing.
- R7: Opcode 6 (0xC0) appends the packet-number register to the transmit queue. The queue-head word shows the transmit head in bits [6:0], and bit 7 is set when that queue is empty. A mac_tx_pop strobe removes the head, and packets leave in first-in first-out order.
- R8: A mac_rx_push strobe appends mac_rx_pkt to the receive queue. The queue-head word shows the receive head in bits [14:8], and bit 15 is set when that queue is empty.
- R9: Opcode 3 (0x60) removes the receive head and leaves its pages allocated.
- R10: Opcode 4 (0x80) removes the receive head and frees its pages. The release uses the same 4-cycle busy window as R5.
- R11: Opcode 7 (0xE0) empties the transmit queue and leaves all pages untouched.
- R12: Opcode 2 (0x40) does the following, even during a release. It empties both queues, returns every page, clears the result byte to 0x80 and drops busy.
- R13: Opcode 0 (0x00) changes nothing. Any command other than opcode 2 that is written while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Command: opcode in [7:5], pages-1 in [4:0] |
| pnr_wr | input | 1 | Packet-number register write strobe |
| pnr_byte | input | 7 | Packet number for free and transmit enqueue |
| mac_rx_push | input | 1 | MAC delivers a received packet |
| mac_rx_pkt | input | 7 | Number of the received packet |
| mac_tx_pop | input | 1 | MAC finished the transmit head |
| alloc_result | output | 8 | Failure flag in bit 7, packet number in [6:0] |
| alloc_done | output | 1 | One-cycle pulse on a successful allocation |
| busy | output | 1 | Page release in progress |
| queue_heads | output | 16 | Receive empty/head in [15:8], transmit empty/head in [7:0] |
| mem_info | output | 16 | Free pages in [15:8], total pages in [7:0] |

## Verification
Allocation is swept over every request size from one page up to one page more than the buffer holds. This checks that success ends exactly at the buffer size. The buffer is also filled one page at a time, which shows that numbers are handed out lowest-first and that the ninth request fails. A fragmented layout then frees a middle packet, leaving four free pages that do not form a run of three. A three-page request must fail there while a two-page request succeeds, and only the contiguous search can tell those apart from a bare free count. Release timing, commands written while busy, and a reset in the middle of a release are each checked cycle by cycle.

// File: rtl/pba_pkg.sv
package pba_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_ALLOC   = 3'd1,
    OP_RESET   = 3'd2,
    OP_RX_DROP = 3'd3,
    OP_RX_FREE = 3'd4,
    OP_FREE    = 3'd5,
    OP_TX_PUSH = 3'd6,
    OP_TX_CLR  = 3'd7
  } op_e;

  localparam logic [7:0] RESULT_NONE    = 8'h80;
  localparam int         RELEASE_CYCLES = 4;

  // queue-head word: an empty queue shows its flag and a zero number
  function automatic logic [15:0] head_word(input logic rx_e, input logic [6:0] rx_h,
                                             input logic tx_e, input logic [6:0] tx_h);
    return {rx_e, (rx_e ? 7'd0 : rx_h), tx_e, (tx_e ? 7'd0 : tx_h)};
  endfunction

  function automatic logic [15:0] info_word(input logic [7:0] free_pg, input logic [7:0] total_pg);
    return {free_pg, total_pg};
  endfunction
endpackage

// File: rtl/pba_queue.sv
module pba_queue #(
  parameter int DEPTH = 8,
  parameter int W     = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire do_push = push && !full && !clear;
  wire do_pop  = pop && !empty && !clear;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  p_push_shows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> !empty);
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_clear_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> empty);
endmodule

// File: rtl/pba_pages.sv
module pba_pages #(
  parameter int NUM_PAGES = 8,
  parameter int REQ_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic [REQ_W-1:0] req_len,
  input  logic             give,
  input  logic [$clog2(NUM_PAGES)-1:0] give_base,
  input  logic [REQ_W-1:0] give_len,
  output logic             fit_ok,
  output logic [$clog2(NUM_PAGES)-1:0] fit_base,
  output logic [$clog2(NUM_PAGES+1)-1:0] free_cnt
);
  localparam int IW = $clog2(NUM_PAGES);
  localparam int CW = $clog2(NUM_PAGES + 1);

  logic [NUM_PAGES-1:0] used;

  // true when pages [s, s+len) lie inside the buffer and are all free
  function automatic logic run_free(input logic [NUM_PAGES-1:0] u, input int s,
                                    input logic [REQ_W-1:0] len);
    logic ok;
    ok = (s + int'(len)) <= NUM_PAGES;
    for (int i = 0; i < NUM_PAGES; i++)
      if (i >= s && i < s + int'(len) && u[i]) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [NUM_PAGES-1:0] span(input int s, input logic [REQ_W-1:0] len);
    logic [NUM_PAGES-1:0] m;
    for (int i = 0; i < NUM_PAGES; i++) m[i] = (i >= s) && (i < s + int'(len));
    return m;
  endfunction

  always_comb begin
    fit_ok   = 1'b0;
    fit_base = '0;
    for (int s = NUM_PAGES - 1; s >= 0; s--) begin
      if (run_free(used, s, req_len)) begin
        fit_ok   = 1'b1;
        fit_base = IW'(s);
      end
    end
  end

  assign free_cnt = CW'(NUM_PAGES) - CW'($countones(used));

  logic [NUM_PAGES-1:0] take_mask, give_mask;
  assign take_mask = (take && fit_ok) ? span(int'(fit_base), req_len) : '0;
  assign give_mask = give ? span(int'(give_base), give_len) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) used <= '0;
    else                 used <= (used | take_mask) & ~give_mask;
  end

  p_take_counts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && fit_ok && !clear && !give) |=>
      int'(free_cnt) == int'($past(free_cnt)) - int'($past(req_len)));
  p_give_counts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (give && !take && !clear) |=>
      int'(free_cnt) == int'($past(free_cnt)) + int'($past(give_len)));
endmodule

// File: rtl/pba_alloc.sv
module pba_alloc #(
  parameter int NUM_PAGES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [7:0]  cmd_byte,
  input  logic        pnr_wr,
  input  logic [6:0]  pnr_byte,
  input  logic        mac_rx_push,
  input  logic [6:0]  mac_rx_pkt,
  input  logic        mac_tx_pop,
  output logic [7:0]  alloc_result,
  output logic        alloc_done,
  output logic        busy,
  output logic [15:0] queue_heads,
  output logic [15:0] mem_info
);
  import pba_pkg::*;

  localparam int NUM_PKTS = NUM_PAGES;
  localparam int IW       = $clog2(NUM_PAGES);
  localparam int PNW      = $clog2(NUM_PKTS);
  localparam int CW       = $clog2(NUM_PAGES + 1);
  localparam int REQ_W    = 6;
  localparam int BW       = $clog2(RELEASE_CYCLES + 1);

  // host register and decoded events
  logic [6:0] pnr;
  op_e        op;
  logic       accept, do_reset, is_alloc, alloc_win, rel_start, rel_fire;
  logic [REQ_W-1:0] req_len;

  // packet table
  logic [NUM_PKTS-1:0] pkt_used;
  logic [IW-1:0]       pkt_base [NUM_PKTS];
  logic [REQ_W-1:0]    pkt_len  [NUM_PKTS];
  logic                slot_ok;
  logic [PNW-1:0]      slot;

  // release engine
  logic [BW-1:0]  busy_cnt;
  logic [PNW-1:0] rel_idx;
  logic [PNW-1:0] start_idx;

  // page map and queues
  logic           fit_ok;
  logic [IW-1:0]  fit_base;
  logic [CW-1:0]  free_cnt;
  logic [6:0]     rx_head, tx_head;
  logic           rx_empty, rx_full, tx_empty, tx_full;

  assign op       = op_e'(cmd_byte[7:5]);
  assign busy     = (busy_cnt != '0);
  assign accept   = cmd_wr && (!busy || op == OP_RESET);
  assign do_reset = accept && (op == OP_RESET);
  assign is_alloc = accept && (op == OP_ALLOC);
  assign req_len  = {1'b0, cmd_byte[4:0]} + REQ_W'(1);
  assign alloc_win = is_alloc && fit_ok && slot_ok;

  always_comb begin
    slot_ok = 1'b0;
    slot    = '0;
    for (int i = NUM_PKTS - 1; i >= 0; i--) begin
      if (!pkt_used[i]) begin
        slot_ok = 1'b1;
        slot    = PNW'(i);
      end
    end
  end

  // which packet a release would start on, and whether it is a live one
  logic pnr_live, rxh_live;
  assign pnr_live  = (pnr < 7'(NUM_PKTS)) && pkt_used[pnr[PNW-1:0]];
  assign rxh_live  = !rx_empty && (rx_head < 7'(NUM_PKTS)) && pkt_used[rx_head[PNW-1:0]];
  assign start_idx = (op == OP_FREE) ? pnr[PNW-1:0] : rx_head[PNW-1:0];
  assign rel_start = accept && ((op == OP_FREE && pnr_live) || (op == OP_RX_FREE && rxh_live));
  assign rel_fire  = (busy_cnt == BW'(1)) && !do_reset;

  always_ff @(posedge clk) begin
    if (!rst_n) pnr <= '0;
    else if (pnr_wr) pnr <= pnr_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || do_reset) begin
      busy_cnt <= '0;
      rel_idx  <= '0;
    end else if (rel_start) begin
      busy_cnt <= BW'(RELEASE_CYCLES);
      rel_idx  <= start_idx;
    end else if (busy) begin
      busy_cnt <= busy_cnt - BW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || do_reset) begin
      pkt_used <= '0;
    end else begin
      if (alloc_win) pkt_used[slot]    <= 1'b1;
      if (rel_fire)  pkt_used[rel_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_win) begin
      pkt_base[slot] <= fit_base;
      pkt_len[slot]  <= req_len;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || do_reset) begin
      alloc_result <= RESULT_NONE;
      alloc_done   <= 1'b0;
    end else begin
      alloc_done <= alloc_win;
      if (is_alloc) alloc_result <= alloc_win ? {1'b0, 7'(slot)} : RESULT_NONE;
    end
  end

  pba_pages #(.NUM_PAGES(NUM_PAGES), .REQ_W(REQ_W)) u_pages (
    .clk(clk), .rst_n(rst_n), .clear(do_reset),
    .take(alloc_win), .req_len(req_len),
    .give(rel_fire), .give_base(pkt_base[rel_idx]), .give_len(pkt_len[rel_idx]),
    .fit_ok(fit_ok), .fit_base(fit_base), .free_cnt(free_cnt)
  );

  pba_queue #(.DEPTH(NUM_PKTS), .W(7)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clear(do_reset),
    .push(mac_rx_push), .push_data(mac_rx_pkt),
    .pop(accept && (op == OP_RX_DROP || op == OP_RX_FREE)),
    .head(rx_head), .empty(rx_empty), .full(rx_full)
  );

  pba_queue #(.DEPTH(NUM_PKTS), .W(7)) u_txq (
    .clk(clk), .rst_n(rst_n), .clear(do_reset || (accept && op == OP_TX_CLR)),
    .push(accept && op == OP_TX_PUSH), .push_data(pnr),
    .pop(mac_tx_pop),
    .head(tx_head), .empty(tx_empty), .full(tx_full)
  );

  assign queue_heads = head_word(rx_empty, rx_head, tx_empty, tx_head);
  assign mem_info    = info_word(8'(free_cnt), 8'(NUM_PAGES));

  p_done_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_done |-> !alloc_result[7]);
  p_fail_keeps_pages_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_alloc && !alloc_win) |=> alloc_result == RESULT_NONE && !alloc_done
                                 && mem_info == $past(mem_info));
  p_release_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rel_start |=> busy);
  p_release_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rel_fire |=> !busy && mem_info[15:8] > $past(mem_info[15:8]));
  p_reset_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
    do_reset |=> queue_heads == 16'h8080 && mem_info[15:8] == mem_info[7:0]
                 && alloc_result == RESULT_NONE && !busy);
  p_busy_blocks_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr && op == OP_ALLOC) |=> !alloc_done);
endmodule

// File: tb/tb_pba_alloc.sv
module tb_pba_alloc;
  localparam int NP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic pnr_wr = 1'b0;
  logic [6:0] pnr_byte = 7'd0;
  logic mac_rx_push = 1'b0;
  logic [6:0] mac_rx_pkt = 7'd0;
  logic mac_tx_pop = 1'b0;
  logic [7:0]  alloc_result;
  logic        alloc_done, busy;
  logic [15:0] queue_heads, mem_info;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pba_alloc #(.NUM_PAGES(NP)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
    .pnr_wr(pnr_wr), .pnr_byte(pnr_byte), .mac_rx_push(mac_rx_push),
    .mac_rx_pkt(mac_rx_pkt), .mac_tx_pop(mac_tx_pop),
    .alloc_result(alloc_result), .alloc_done(alloc_done), .busy(busy),
    .queue_heads(queue_heads), .mem_info(mem_info)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] b);
    cmd_wr = 1'b1; cmd_byte = b; tick(); cmd_wr = 1'b0; cmd_byte = 8'h00;
  endtask

  task automatic setp(input logic [6:0] n);
    pnr_wr = 1'b1; pnr_byte = n; tick(); pnr_wr = 1'b0;
  endtask

  task automatic rxpush(input logic [6:0] n);
    mac_rx_push = 1'b1; mac_rx_pkt = n; tick(); mac_rx_push = 1'b0;
  endtask

  task automatic txpop();
    mac_tx_pop = 1'b1; tick(); mac_tx_pop = 1'b0;
  endtask

  function automatic logic [7:0] alloc_op(input int pages);
    return 8'h20 | 8'(pages - 1);
  endfunction

  function automatic logic [15:0] info(input int free_pg);
    return {8'(free_pg), 8'(NP)};
  endfunction

  // expects the release started in the cycle just sampled
  task automatic watch_release(input string req, input int free_before, input int freed);
    for (int c = 0; c < 4; c++) begin
      chk(req, {15'd0, busy}, 16'd1);
      chk(req, mem_info, info(free_before));
      tick();
    end
    chk(req, {15'd0, busy}, 16'd0);
    chk(req, mem_info, info(free_before + freed));
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state, R4 info layout
    chk("R1", {8'd0, alloc_result}, 16'h0080);
    chk("R1", queue_heads, 16'h8080);
    chk("R4", mem_info, info(NP));
    chk("R1", {15'd0, busy}, 16'd0);

    // R2/R3 sweep of request sizes from an empty buffer
    for (int n = 1; n <= NP + 1; n++) begin
      cmd(alloc_op(n));
      if (n <= NP) begin
        chk("R2", {8'd0, alloc_result}, 16'h0000);
        chk("R2", {15'd0, alloc_done}, 16'd1);
        chk("R4", mem_info, info(NP - n));
        tick();
        chk("R2", {15'd0, alloc_done}, 16'd0);
      end else begin
        chk("R3", {8'd0, alloc_result}, 16'h0080);
        chk("R3", {15'd0, alloc_done}, 16'd0);
        chk("R3", mem_info, info(NP));
      end
      cmd(8'h40);
      chk("R12", mem_info, info(NP));
    end

    // R2 lowest-number-first fill, R3 on exhaustion
    for (int k = 0; k < NP; k++) begin
      cmd(alloc_op(1));
      chk("R2", {8'd0, alloc_result}, 16'(k));
      chk("R4", mem_info, info(NP - 1 - k));
    end
    cmd(alloc_op(1));
    chk("R3", {8'd0, alloc_result}, 16'h0080);

    // R5 free a middle packet, 4-cycle busy, number reused
    setp(7'd3);
    cmd(8'hA0);
    watch_release("R5", 0, 1);
    cmd(alloc_op(1));
    chk("R5", {8'd0, alloc_result}, 16'h0003);

    // R6 free of an unallocated number
    cmd(8'h40);
    setp(7'd5);
    cmd(8'hA0);
    chk("R6", {15'd0, busy}, 16'd0);
    chk("R6", mem_info, info(NP));

    // R3 contiguity: four free pages that hold no run of three
    cmd(alloc_op(2)); cmd(alloc_op(2)); cmd(alloc_op(2));
    chk("R2", {8'd0, alloc_result}, 16'h0002);
    setp(7'd1);
    cmd(8'hA0);
    watch_release("R5", 2, 2);
    cmd(alloc_op(3));
    chk("R3", {8'd0, alloc_result}, 16'h0080);
    chk("R3", mem_info, info(4));
    cmd(alloc_op(2));
    chk("R2", {8'd0, alloc_result}, 16'h0001);
    cmd(alloc_op(2));
    chk("R2", {8'd0, alloc_result}, 16'h0003);
    chk("R4", mem_info, info(0));

    // R13 commands ignored while busy, no-op
    setp(7'd0);
    cmd(8'hA0);
    cmd(alloc_op(1));
    chk("R13", {15'd0, alloc_done}, 16'd0);
    chk("R13", {8'd0, alloc_result}, 16'h0003);
    tick(); tick(); tick();
    chk("R13", mem_info, info(2));
    cmd(8'h00);
    chk("R13", mem_info, info(2));
    chk("R13", queue_heads, 16'h8080);
    chk("R13", {8'd0, alloc_result}, 16'h0003);

    // R7 transmit queue order, R11 clear
    cmd(8'h40);
    cmd(alloc_op(1)); cmd(alloc_op(1)); cmd(alloc_op(1));
    setp(7'd2); cmd(8'hC0);
    setp(7'd0); cmd(8'hC0);
    chk("R7", queue_heads, 16'h8002);
    txpop();
    chk("R7", queue_heads, 16'h8000);
    txpop();
    chk("R7", queue_heads, 16'h8080);
    setp(7'd1); cmd(8'hC0);
    chk("R7", queue_heads, 16'h8001);
    cmd(8'hE0);
    chk("R11", queue_heads, 16'h8080);
    chk("R11", mem_info, info(NP - 3));

    // R8 receive queue, R9 drop, R10 drop-and-free
    rxpush(7'd1);
    rxpush(7'd2);
    chk("R8", queue_heads, 16'h0180);
    cmd(8'h60);
    chk("R9", queue_heads, 16'h0280);
    chk("R9", mem_info, info(NP - 3));
    chk("R9", {15'd0, busy}, 16'd0);
    cmd(8'h80);
    chk("R10", queue_heads, 16'h8080);
    watch_release("R10", NP - 3, 1);

    // R12 reset during a release
    setp(7'd0);
    cmd(8'hA0);
    chk("R12", {15'd0, busy}, 16'd1);
    cmd(8'h40);
    chk("R12", {15'd0, busy}, 16'd0);
    chk("R12", mem_info, info(NP));
    chk("R12", {8'd0, alloc_result}, 16'h0080);
    tick(); tick(); tick(); tick();
    chk("R12", mem_info, info(NP));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule